// File: doc/BRIEF.md
# ALU Slice with Stored-Function Register

This block is the arithmetic and logic slice of a microcoded datapath. Two operand holding registers (A and B) load from the datapath when their load strobes are raised. A 4-bit function code from the current microinstruction picks the operation. One function code, the escape code, hands the choice of operation to an 8-bit stored-function register. Software fills that register by placing a byte in the low half of the B holding register and pulsing the cycle-1 strobe while the load enable is high.

Each clock with the step enable high captures the slice output in a result register, together with its sign, carry, zero and overflow flags. A status readback word, driven all the time, packs those flags and the stored-function register into one active-low 16-bit value. A mask input can replace the B operand for any operation.

Top module: `alu_sfr_slice`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register clears: `result` reads 0 and `status_n` reads 16'hFFFF.
- R2: Function code 0 outputs the effective B operand, with carry and overflow both 0.
- R3: Function code 9 outputs A+B mod 2^16, and code 10 outputs A+B+1. Carry is the bit that leaves the top of the 16-bit sum.
- R4: For every adder operation, overflow equals the carry into bit 15 XOR the carry out of bit 15, which is signed two's-complement overflow.
- R5: The sign flag is bit 15 of the result. The zero flag is 1 exactly when the captured result is 0.
- R6: With `mask_sel` high, the 16-bit `mask_d` takes the place of the B holding register as the B operand. B then reads `mask_d` for every operation.
- R7: Function code 15 takes the operation from the stored-function register. With the mode bits [7:6]=01, the function field [5:0] selects: 0 A+B, 1 A+B+1, 2 A-B, 3 A-B-1, 4 A+1, 5 A-1.
- R8: With code 15 and mode bits [7:6]=00, the function field selects: 0 A AND B, 1 A OR B, 2 A XOR B, 3 NOT A, 4 pass B. Logic operations give carry 0 and overflow 0.
- R9: Each of the following outputs A, with carry 0 and overflow 0: any other function code (1-8, 11-14), any unlisted function field, and mode bits 10 or 11.
- R10: The stored-function register loads bits [7:0] of the B holding register at a clock edge where `cyc1_strobe` and `sfr_ld_en` are both high. In every other cycle it holds its value.
- R11: `status_n` is the bitwise inverse of {sign, carry, zero, overflow, 4'b0000, stored-function[7:0]}. Bit 15 is sign, bit 12 is overflow, bits 7..0 are the stored function.
- R12: When `step_en` is low, the result register and its flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opa_ld | input | 1 | Load A holding register from `opa_d` |
| opa_d | input | 16 | A operand data |
| opb_ld | input | 1 | Load B holding register from `opb_d` |
| opb_d | input | 16 | B operand data |
| mask_sel | input | 1 | Replace the B operand with `mask_d` |
| mask_d | input | 16 | Mask value |
| fcode | input | 4 | Microinstruction function code |
| cyc1_strobe | input | 1 | Cycle-1 strobe for the stored-function register |
| sfr_ld_en | input | 1 | Load enable for the stored-function register |
| step_en | input | 1 | Capture the ALU output and flags |
| result | output | 16 | Result register |
| status_n | output | 16 | Active-low status word |

## Verification
The hardest state to reach from the ports is the escape path paired with a given stored function. That path needs three clock steps in order: a byte placed in B, a strobe with the enable high, and then an operation with code 15 on fresh operands. The stimulus runs these steps many times with random bytes, some drawn from the implemented mode/function pairs and some left unconstrained. It also pulses the strobe with the enable low and checks through `status_n` that the stored value did not change. Directed operands (0x7FFF+1, 0x8000+0x8000, 0xFFFF+1) set overflow, carry and zero on their own and in combination.

// File: rtl/alu_sfr_pkg.sv
// Package: shared operation encoding for the ALU slice.
// Assumes: microinstruction codes and stored-function fields fixed as below.
package alu_sfr_pkg;

    localparam int FC_W     = 4;
    localparam int SFR_W    = 8;
    localparam int SFN_W    = 6;

    localparam logic [FC_W-1:0] FC_PASS_B = 4'd0;
    localparam logic [FC_W-1:0] FC_ADD    = 4'd9;
    localparam logic [FC_W-1:0] FC_ADD1   = 4'd10;
    localparam logic [FC_W-1:0] FC_STORED = 4'd15;

    localparam logic [1:0] MODE_LOGIC = 2'b00;
    localparam logic [1:0] MODE_ARITH = 2'b01;

    typedef enum logic [2:0] {
        K_PASS_A = 3'd0,
        K_PASS_B = 3'd1,
        K_ADD    = 3'd2,
        K_AND    = 3'd3,
        K_OR     = 3'd4,
        K_XOR    = 3'd5,
        K_NOT_A  = 3'd6
    } op_kind_e;

    typedef struct packed {
        op_kind_e kind;
        logic     y_zero;   // adder second input forced to zero before inversion
        logic     y_inv;    // adder second input inverted
        logic     cin;      // adder carry in
    } op_ctl_t;

endpackage

// File: rtl/alu_sfr_decode.sv
// Module: function decoder.
// Maps the microinstruction code, or the stored function when the escape
// code is present, onto one operation control word. Anything undefined
// becomes pass-A so the output is always known.
module alu_sfr_decode
    import alu_sfr_pkg::*;
(
    input  logic [FC_W-1:0]  fcode,
    input  logic [SFR_W-1:0] sfr,
    output op_ctl_t          ctl
);

    localparam op_ctl_t PASS_A = '{kind: K_PASS_A, y_zero: 1'b0, y_inv: 1'b0, cin: 1'b0};

    logic [1:0]       mode;
    logic [SFN_W-1:0] fn;
    op_ctl_t          stored_ctl;

    assign mode = sfr[SFR_W-1 -: 2];
    assign fn   = sfr[SFN_W-1:0];

    // Purpose: decode the stored-function register into a control word.
    always_comb begin
        stored_ctl = PASS_A;
        if (mode == MODE_ARITH) begin
            unique case (fn)
                6'd0: stored_ctl = '{kind: K_ADD, y_zero: 1'b0, y_inv: 1'b0, cin: 1'b0};
                6'd1: stored_ctl = '{kind: K_ADD, y_zero: 1'b0, y_inv: 1'b0, cin: 1'b1};
                6'd2: stored_ctl = '{kind: K_ADD, y_zero: 1'b0, y_inv: 1'b1, cin: 1'b1};
                6'd3: stored_ctl = '{kind: K_ADD, y_zero: 1'b0, y_inv: 1'b1, cin: 1'b0};
                6'd4: stored_ctl = '{kind: K_ADD, y_zero: 1'b1, y_inv: 1'b0, cin: 1'b1};
                6'd5: stored_ctl = '{kind: K_ADD, y_zero: 1'b1, y_inv: 1'b1, cin: 1'b0};
                default: stored_ctl = PASS_A;
            endcase
        end else if (mode == MODE_LOGIC) begin
            unique case (fn)
                6'd0: stored_ctl.kind = K_AND;
                6'd1: stored_ctl.kind = K_OR;
                6'd2: stored_ctl.kind = K_XOR;
                6'd3: stored_ctl.kind = K_NOT_A;
                6'd4: stored_ctl.kind = K_PASS_B;
                default: stored_ctl = PASS_A;
            endcase
        end
    end

    // Purpose: select between microinstruction codes and the stored function.
    always_comb begin
        ctl = PASS_A;
        unique case (fcode)
            FC_PASS_B: ctl.kind = K_PASS_B;
            FC_ADD:    ctl = '{kind: K_ADD, y_zero: 1'b0, y_inv: 1'b0, cin: 1'b0};
            FC_ADD1:   ctl = '{kind: K_ADD, y_zero: 1'b0, y_inv: 1'b0, cin: 1'b1};
            FC_STORED: ctl = stored_ctl;
            default:   ctl = PASS_A;
        endcase
    end

endmodule

// File: rtl/alu_sfr_core.sv
// Module: combinational ALU core.
// Computes the result word plus carry and overflow for one control word.
// Assumes: operands are already selected; only adder operations set flags.
module alu_sfr_core
    import alu_sfr_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  op_ctl_t          ctl,
    output logic [WIDTH-1:0] res,
    output logic             carry,
    output logic             ovf
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] y_base;
    logic [WIDTH-1:0] y_add;
    logic [WIDTH:0]   sum;
    logic             c_into_msb;

    assign y_base = ctl.y_zero ? '0 : opb;
    assign y_add  = ctl.y_inv ? ~y_base : y_base;

    // Purpose: ripple-free adder with the carry-in folded in.
    always_comb begin
        sum        = {1'b0, opa} + {1'b0, y_add} + {{WIDTH{1'b0}}, ctl.cin};
        c_into_msb = opa[MSB] ^ y_add[MSB] ^ sum[MSB];
    end

    // Purpose: pick the output word and flags for the selected kind.
    always_comb begin
        res   = opa;
        carry = 1'b0;
        ovf   = 1'b0;
        unique case (ctl.kind)
            K_PASS_A: res = opa;
            K_PASS_B: res = opb;
            K_ADD: begin
                res   = sum[WIDTH-1:0];
                carry = sum[WIDTH];
                ovf   = c_into_msb ^ sum[WIDTH];
            end
            K_AND:   res = opa & opb;
            K_OR:    res = opa | opb;
            K_XOR:   res = opa ^ opb;
            K_NOT_A: res = ~opa;
            default: res = opa;
        endcase
    end

endmodule

// File: rtl/alu_sfr_store.sv
// Module: stored-function register.
// Loads the low byte of the B holding register on a cycle-1 strobe when
// enabled, and otherwise keeps its value. Synchronous active-low reset.
module alu_sfr_store
    import alu_sfr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic             ld_en,
    input  logic [SFR_W-1:0] din,
    output logic [SFR_W-1:0] q
);

    // Purpose: hold or reload the stored function.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (strobe && ld_en)
            q <= din;
    end

    AST_SFR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe && ld_en) |=> $stable(q)); // R10
    AST_SFR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && ld_en) |=> q == $past(din)); // R10

endmodule

// File: rtl/alu_sfr_slice.sv
// Module: top of the ALU slice.
// Holds the A/B operands, applies the mask override, decodes the function,
// captures result and flags on step, and drives the active-low status word.
// Assumes: WIDTH >= 12 so flags, padding and stored function fit the status word.
module alu_sfr_slice
    import alu_sfr_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             opa_ld,
    input  logic [WIDTH-1:0] opa_d,
    input  logic             opb_ld,
    input  logic [WIDTH-1:0] opb_d,
    input  logic             mask_sel,
    input  logic [WIDTH-1:0] mask_d,
    input  logic [FC_W-1:0]  fcode,
    input  logic             cyc1_strobe,
    input  logic             sfr_ld_en,
    input  logic             step_en,
    output logic [WIDTH-1:0] result,
    output logic [WIDTH-1:0] status_n
);

    localparam int PAD_W = WIDTH - 4 - SFR_W;

    logic [WIDTH-1:0] a_hold, b_hold, b_eff;
    logic [SFR_W-1:0] sfr_q;
    op_ctl_t          ctl;
    logic [WIDTH-1:0] alu_res;
    logic             alu_carry, alu_ovf;
    logic             carry_q, ovf_q, zero_q;

    // Purpose: operand holding registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_hold <= '0;
            b_hold <= '0;
        end else begin
            if (opa_ld) a_hold <= opa_d;
            if (opb_ld) b_hold <= opb_d;
        end
    end

    assign b_eff = mask_sel ? mask_d : b_hold;

    alu_sfr_store u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (cyc1_strobe),
        .ld_en  (sfr_ld_en),
        .din    (b_hold[SFR_W-1:0]),
        .q      (sfr_q)
    );

    alu_sfr_decode u_decode (
        .fcode (fcode),
        .sfr   (sfr_q),
        .ctl   (ctl)
    );

    alu_sfr_core #(.WIDTH(WIDTH)) u_core (
        .opa   (a_hold),
        .opb   (b_eff),
        .ctl   (ctl),
        .res   (alu_res),
        .carry (alu_carry),
        .ovf   (alu_ovf)
    );

    // Purpose: result register and its flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result  <= '0;
            carry_q <= 1'b0;
            ovf_q   <= 1'b0;
            zero_q  <= 1'b0;
        end else if (step_en) begin
            result  <= alu_res;
            carry_q <= alu_carry;
            ovf_q   <= alu_ovf;
            zero_q  <= (alu_res == '0);
        end
    end

    // Purpose: active-low status readback word.
    assign status_n = ~{result[WIDTH-1], carry_q, zero_q, ovf_q, {PAD_W{1'b0}}, sfr_q};

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(result) && $stable(status_n[WIDTH-1 -: 4])); // R12
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> zero_q == (result == '0)); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && ctl.kind != K_ADD) |=> !ovf_q && !carry_q); // R8
    AST_OVF_SIGNS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.kind == K_ADD) |-> alu_ovf == ((a_hold[WIDTH-1] == u_core.y_add[WIDTH-1])
                                            && (alu_res[WIDTH-1] != a_hold[WIDTH-1]))); // R4
    AST_PASS_B: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && fcode == FC_PASS_B) |=> result == $past(b_eff)); // R2

endmodule

// File: tb/alu_sfr_slice_test.sv
module alu_sfr_slice_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        opa_ld, opb_ld, mask_sel, cyc1_strobe, sfr_ld_en, step_en;
    logic [15:0] opa_d, opb_d, mask_d;
    logic [3:0]  fcode;
    logic [15:0] result, status_n;

    int errors = 0;
    int checks = 0;
    logic [7:0] m_sfr = 8'h00;
    logic [15:0] m_res = 16'h0;
    logic m_c = 1'b0, m_v = 1'b0;

    always #2.5 clk = ~clk;

    alu_sfr_slice uut (
        .clk(clk), .rst_n(rst_n), .opa_ld(opa_ld), .opa_d(opa_d),
        .opb_ld(opb_ld), .opb_d(opb_d), .mask_sel(mask_sel), .mask_d(mask_d),
        .fcode(fcode), .cyc1_strobe(cyc1_strobe), .sfr_ld_en(sfr_ld_en),
        .step_en(step_en), .result(result), .status_n(status_n)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Adder model: signed overflow from operand and sum signs.
    function automatic logic [17:0] m_add(input logic [15:0] a, input logic [15:0] y, input logic ci);
        logic [16:0] s;
        logic v;
        s = {1'b0, a} + {1'b0, y} + 17'(ci);
        v = (a[15] == y[15]) && (s[15] != a[15]);
        return {v, s[16], s[15:0]};
    endfunction

    // Reference function: returns {ovf, carry, result}.
    function automatic logic [17:0] m_op(input logic [15:0] a, input logic [15:0] b,
                                         input logic [3:0] fc, input logic [7:0] sf);
        if (fc == 4'd0) return {2'b00, b};
        if (fc == 4'd9) return m_add(a, b, 1'b0);
        if (fc == 4'd10) return m_add(a, b, 1'b1);
        if (fc != 4'd15) return {2'b00, a};
        if (sf[7:6] == 2'b01) begin
            case (sf[5:0])
                6'd0: return m_add(a, b, 1'b0);
                6'd1: return m_add(a, b, 1'b1);
                6'd2: return m_add(a, ~b, 1'b1);
                6'd3: return m_add(a, ~b, 1'b0);
                6'd4: return m_add(a, 16'h0000, 1'b1);
                6'd5: return m_add(a, 16'hFFFF, 1'b0);
                default: return {2'b00, a};
            endcase
        end
        if (sf[7:6] == 2'b00) begin
            case (sf[5:0])
                6'd0: return {2'b00, a & b};
                6'd1: return {2'b00, a | b};
                6'd2: return {2'b00, a ^ b};
                6'd3: return {2'b00, ~a};
                6'd4: return {2'b00, b};
                default: return {2'b00, a};
            endcase
        end
        return {2'b00, a};
    endfunction

    function automatic logic [15:0] m_status();
        return ~{m_res[15], m_c, m_res == 16'h0, m_v, 4'h0, m_sfr};
    endfunction

    task automatic idle();
        opa_ld = 0; opb_ld = 0; cyc1_strobe = 0; sfr_ld_en = 0; step_en = 0;
    endtask

    // Place a byte in B and strobe; en selects whether it should take.
    task automatic load_sfr(input logic [7:0] v, input logic en, input string req);
        @(negedge clk); idle(); opb_ld = 1; opb_d = {$urandom} [15:0];
        opb_d[7:0] = v;
        @(negedge clk); idle(); cyc1_strobe = 1; sfr_ld_en = en;
        if (!en && ($urandom % 2)) begin cyc1_strobe = 0; sfr_ld_en = 1; end
        @(negedge clk); idle();
        if (en) m_sfr = v;
        check(req, status_n, m_status());
    endtask

    // Load operands, step once, compare result and status.
    task automatic do_op(input logic [15:0] a, input logic [15:0] b, input logic ms,
                         input logic [15:0] mk, input logic [3:0] fc, input string req);
        logic [17:0] e;
        @(negedge clk); idle(); opa_ld = 1; opb_ld = 1; opa_d = a; opb_d = b;
        @(negedge clk); idle(); mask_sel = ms; mask_d = mk; fcode = fc; step_en = 1;
        @(negedge clk); idle();
        e = m_op(a, ms ? mk : b, fc, m_sfr);
        m_res = e[15:0]; m_c = e[16]; m_v = e[17];
        check(req, result, m_res);
        check(req, status_n, m_status());
        mask_sel = 0;
    endtask

    bit done = 0;
    initial begin
        for (int cyc = 0; cyc < 150000 && !done; cyc++) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        idle(); mask_sel = 0; mask_d = 0; opa_d = 0; opb_d = 0; fcode = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        check("R1 result", result, 16'h0000);
        check("R1 status", status_n, 16'hFFFF);
        rst_n = 1;

        // Directed corners
        do_op(16'h1234, 16'hABCD, 0, 16'h0, 4'd0, "R2");
        do_op(16'h7FFF, 16'h0001, 0, 16'h0, 4'd9, "R3 R4 overflow");
        do_op(16'h8000, 16'h8000, 0, 16'h0, 4'd9, "R3 R4 R5 carry+zero");
        do_op(16'hFFFF, 16'h0000, 0, 16'h0, 4'd10, "R3 R5 wrap");
        do_op(16'h0005, 16'h9999, 1, 16'h00F0, 4'd9, "R6 mask add");
        do_op(16'h0005, 16'h9999, 1, 16'hC3C3, 4'd0, "R6 mask pass");
        do_op(16'h4321, 16'h1111, 0, 16'h0, 4'd3, "R9 other code");
        // R12: no step, result and flags hold
        @(negedge clk); idle(); opa_ld = 1; opa_d = 16'hDEAD; fcode = 4'd0;
        @(negedge clk); idle();
        check("R12 hold result", result, m_res);
        check("R12 hold status", status_n, m_status());
        // R10: strobe without enable is ignored
        load_sfr(8'h42, 1, "R10 R11 load");
        load_sfr(8'h01, 0, "R10 ignored");
        do_op(16'h0010, 16'h0003, 0, 16'h0, 4'd15, "R7 A-B");
        load_sfr(8'h45, 1, "R10 load A-1");
        do_op(16'h0000, 16'h0003, 0, 16'h0, 4'd15, "R7 R4 A-1");
        load_sfr(8'h02, 1, "R10 load xor");
        do_op(16'hF0F0, 16'hFF00, 0, 16'h0, 4'd15, "R8 xor");
        load_sfr(8'h80, 1, "R10 mode10");
        do_op(16'h5A5A, 16'h0101, 0, 16'h0, 4'd15, "R9 mode10");

        // Constrained random
        for (int i = 0; i < 600; i++) begin
            int unsigned pick = $urandom % 8;
            logic [3:0] fc;
            logic [15:0] a, b;
            if (pick == 0) begin
                logic [7:0] v;
                v = ($urandom % 2) ? {1'b0, 1'($urandom % 2), 6'($urandom % 7)} : 8'($urandom);
                load_sfr(v, 1'($urandom % 4 != 0), "R10 R11 random");
            end
            case ($urandom % 5)
                0: fc = 4'd0; 1: fc = 4'd9; 2: fc = 4'd10; 3: fc = 4'd15;
                default: fc = 4'($urandom);
            endcase
            a = ($urandom % 6 == 0) ? 16'h8000 : 16'($urandom);
            b = ($urandom % 6 == 0) ? 16'h7FFF : 16'($urandom);
            do_op(a, b, 1'($urandom % 5 == 0), 16'($urandom), fc, "R3 R7 R8 R9 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule